// File: doc/BRIEF.md
# Trip-Count Aged Victim Cache Set

This block holds one set of an exclusive last-level cache that serves as a victim store for the L2. Lines enter only when the L2 evicts them. A lookup that hits removes the line and sends it back to the L2. Because a line leaves on every hit, the set cannot track how recently a line was used. Each way instead records a 2-bit age, and that age is chosen at insertion from the 1-bit trip count that the line carries.

A line whose trip count is 1 has already come back from this cache once, so it is inserted with the highest age and is the last to be chosen as a victim. A line with trip count 0 has never been reused. It is inserted at age 0 or age 1, and an external dueling select picks which. When a fill arrives and no way is free, the valid way with the lowest age is evicted. The tag and trip count of that line are presented for one cycle. All surviving ages then shift down by the victim's age, which keeps their relative order. Data payload, coherence and memory access are handled elsewhere.

Top module: `tcage_victim_set`

## Requirements
- R1: While reset is asserted and after it is released, every way is invalid and hit_o, hit_tc_o and evict_valid_o are 0.
- R2: When a lookup matches a valid way, hit_o is 1 in the next cycle, hit_way_o gives that way and hit_tc_o is 1. The way becomes invalid, so a repeat lookup of the same tag misses.
- R3: A lookup that matches no valid way gives hit_o = 0 in the next cycle and leaves every way unchanged.
- R4: A fill with fill_tc_i = 1 is inserted with age 3, reported on fill_age_o in the next cycle.
- R5: A fill with fill_tc_i = 0 is inserted with age 0 when duel_sel_i = 0 and with age 1 when duel_sel_i = 1.
- R6: A fill goes into the lowest-indexed invalid way whenever one exists, reported on fill_way_o, and no eviction occurs.
- R7: A fill into a full set replaces the valid way with the smallest age, taking the lowest index on a tie. evict_valid_o is 1 for exactly the next cycle, with evict_tag_o holding the victim's tag.
- R8: On such an eviction, every other resident way's age drops by the victim's age, so the order among residents is kept.
- R9: When a lookup and a fill arrive in the same cycle, the lookup is applied first. A way freed by its hit is available to the fill, so no eviction happens.
- R10: evict_tc_o gives the trip count the victim carried when it was filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request from L2 |
| lookup_tag_i | input | TAG_W | Lookup tag |
| fill_valid_i | input | 1 | Fill request (L2 eviction) |
| fill_tag_i | input | TAG_W | Tag of the line being filled |
| fill_tc_i | input | 1 | Trip count carried by the filled line |
| duel_sel_i | input | 1 | Insertion age for trip-count-0 fills (0 or 1) |
| hit_o | output | 1 | Lookup hit; the line returns to L2 |
| hit_way_o | output | WAY_W | Way that hit |
| hit_tc_o | output | 1 | Trip count attached to the returned line |
| fill_way_o | output | WAY_W | Way written by the last fill |
| fill_age_o | output | 2 | Age given to the last fill |
| evict_valid_o | output | 1 | One-cycle eviction strobe |
| evict_tag_o | output | TAG_W | Tag of the evicted line |
| evict_tc_o | output | 1 | Trip count of the evicted line |

## Verification
The hardest state to reach is a full set whose ages have already been shifted down by earlier evictions, so that the victim choice rests on a tie. Such a tie can only arise from several ordered fills with mixed trip counts and dueling values. A second hard case is a fill that arrives together with a hitting lookup while the set is full. A directed sequence builds both states one step at a time. A long pseudo-random phase then keeps the set near full, choosing fill tags from a unique counter and lookup tags from current residents or known misses. A behavioural model checks the outputs on every clock.

// File: rtl/tcage_pkg.sv
package tcage_pkg;
  typedef logic [1:0] age_t;

  localparam age_t AGE_REUSED = 2'd3;

  // trip count 1 lines are kept longest; never-reused lines follow the duel
  function automatic age_t ins_age(input logic tc, input logic duel);
    if (tc) return AGE_REUSED;
    return {1'b0, duel};
  endfunction
endpackage

// File: rtl/tcage_victim_pick.sv
module tcage_victim_pick #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0]      vld_i,
  input  logic [NUM_WAYS-1:0][1:0] age_i,
  output logic                     free_o,
  output logic [WAY_W-1:0]         free_idx_o,
  output logic [WAY_W-1:0]         min_idx_o,
  output logic [1:0]               min_age_o
);
  logic found;

  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = NUM_WAYS-1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_o     = 1'b1;
        free_idx_o = WAY_W'(i);
      end
    end
  end

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found     = 1'b0;
    min_idx_o = '0;
    min_age_o = 2'd3;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (vld_i[i] && (!found || age_i[i] < min_age_o)) begin
        found     = 1'b1;
        min_idx_o = WAY_W'(i);
        min_age_o = age_i[i];
      end
    end
  end
endmodule

// File: rtl/tcage_tag_match.sv
module tcage_tag_match #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 12,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                          en_i,
  input  logic [NUM_WAYS-1:0]           vld_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]              key_i,
  output logic [NUM_WAYS-1:0]           match_o,
  output logic                          hit_o,
  output logic [WAY_W-1:0]              idx_o
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign match_o[g] = en_i && vld_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_WAYS-1; i >= 0; i--) begin
      if (match_o[i]) idx_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/tcage_victim_set.sv
module tcage_victim_set #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 12,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  input  logic             fill_valid_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_tc_i,
  input  logic             duel_sel_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic             hit_tc_o,
  output logic [WAY_W-1:0] fill_way_o,
  output logic [1:0]       fill_age_o,
  output logic             evict_valid_o,
  output logic [TAG_W-1:0] evict_tag_o,
  output logic             evict_tc_o
);
  import tcage_pkg::*;

  logic [NUM_WAYS-1:0]            vld_q, vld_d, vld_mid, match;
  logic [NUM_WAYS-1:0]            tc_q, tc_d;
  logic [NUM_WAYS-1:0][1:0]       age_q, age_d;
  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q, tag_d;

  logic             lk_hit;
  logic [WAY_W-1:0] lk_idx;
  logic             free;
  logic [WAY_W-1:0] free_idx, min_idx, way;
  logic [1:0]       min_age;
  age_t             ins;

  logic             hit_d, hit_tc_d, ev_d, ev_tc_d;
  logic [WAY_W-1:0] hit_way_d, fway_d;
  logic [1:0]       fage_d;
  logic [TAG_W-1:0] ev_tag_d;

  tcage_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .en_i    (lookup_valid_i),
    .vld_i   (vld_q),
    .tag_i   (tag_q),
    .key_i   (lookup_tag_i),
    .match_o (match),
    .hit_o   (lk_hit),
    .idx_o   (lk_idx)
  );

  // lookup is applied before the fill in the same cycle
  assign vld_mid = vld_q & ~match;

  tcage_victim_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .vld_i      (vld_mid),
    .age_i      (age_q),
    .free_o     (free),
    .free_idx_o (free_idx),
    .min_idx_o  (min_idx),
    .min_age_o  (min_age)
  );

  assign ins = ins_age(fill_tc_i, duel_sel_i);
  assign way = free ? free_idx : min_idx;

  always_comb begin
    vld_d     = vld_mid;
    tc_d      = tc_q;
    age_d     = age_q;
    tag_d     = tag_q;
    hit_d     = lk_hit;
    hit_tc_d  = lk_hit;
    hit_way_d = lk_hit ? lk_idx : hit_way_o;
    ev_d      = 1'b0;
    ev_tag_d  = '0;
    ev_tc_d   = 1'b0;
    fway_d    = fill_way_o;
    fage_d    = fill_age_o;
    if (fill_valid_i) begin
      if (!free) begin
        ev_d     = 1'b1;
        ev_tag_d = tag_q[min_idx];
        ev_tc_d  = tc_q[min_idx];
        // shift every resident down by the victim age; order is kept
        for (int i = 0; i < NUM_WAYS; i++) begin
          age_d[i] = age_q[i] - min_age;
        end
      end
      vld_d[way] = 1'b1;
      tag_d[way] = fill_tag_i;
      tc_d[way]  = fill_tc_i;
      age_d[way] = ins;
      fway_d     = way;
      fage_d     = ins;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      tc_q  <= '0;
      age_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      tc_q  <= tc_d;
      age_q <= age_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o         <= 1'b0;
      hit_way_o     <= '0;
      hit_tc_o      <= 1'b0;
      fill_way_o    <= '0;
      fill_age_o    <= '0;
      evict_valid_o <= 1'b0;
      evict_tag_o   <= '0;
      evict_tc_o    <= 1'b0;
    end else begin
      hit_o         <= hit_d;
      hit_way_o     <= hit_way_d;
      hit_tc_o      <= hit_tc_d;
      fill_way_o    <= fway_d;
      fill_age_o    <= fage_d;
      evict_valid_o <= ev_d;
      evict_tag_o   <= ev_tag_d;
      evict_tc_o    <= ev_tc_d;
    end
  end
endmodule

// File: rtl/tcage_victim_set_chk.sv
module tcage_victim_set_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lookup_valid_i,
  input logic fill_valid_i,
  input logic fill_tc_i,
  input logic duel_sel_i,
  input logic hit_o,
  input logic hit_tc_o,
  input logic evict_valid_o,
  input logic [1:0] fill_age_o
);
  // R2
  hit_needs_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lookup_valid_i));

  // R2
  hit_returns_tc1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_tc_o);

  // R7
  evict_needs_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> $past(fill_valid_i));

  // R9
  no_evict_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> !hit_o);

  // R4
  reused_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_tc_i) |=> (fill_age_o == 2'd3));

  // R5
  fresh_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_tc_i) |=> (fill_age_o == {1'b0, $past(duel_sel_i)}));
endmodule

bind tcage_victim_set tcage_victim_set_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_valid_i (lookup_valid_i),
  .fill_valid_i   (fill_valid_i),
  .fill_tc_i      (fill_tc_i),
  .duel_sel_i     (duel_sel_i),
  .hit_o          (hit_o),
  .hit_tc_o       (hit_tc_o),
  .evict_valid_o  (evict_valid_o),
  .fill_age_o     (fill_age_o)
);

// File: tb/tcage_victim_set_bench.sv
module tcage_victim_set_bench;
  localparam int NW = 4;
  localparam int TW = 12;
  localparam int WW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lookup_valid_i = 1'b0, fill_valid_i = 1'b0, fill_tc_i = 1'b0, duel_sel_i = 1'b0;
  logic [TW-1:0] lookup_tag_i = '0, fill_tag_i = '0;
  logic hit_o, hit_tc_o, evict_valid_o, evict_tc_o;
  logic [WW-1:0] hit_way_o, fill_way_o;
  logic [1:0] fill_age_o;
  logic [TW-1:0] evict_tag_o;

  always #5 clk_i = ~clk_i;

  tcage_victim_set #(.NUM_WAYS(NW), .TAG_W(TW)) u_tcage_victim_set (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int next_tag = 1;

  // behavioural model
  int mv[NW], mtag[NW], mtc[NW], mage[NW];

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit lv, input int lt, input bit fv, input int ft,
                      input bit ftc, input bit duel);
    int e_hit, e_hway, e_ev, e_evtag, e_evtc, e_fway, e_fage;
    int free_w, min_w, min_a;
    e_hit = 0; e_hway = 0; e_ev = 0; e_evtag = 0; e_evtc = 0; e_fway = 0; e_fage = 0;
    if (lv) begin
      for (int i = 0; i < NW; i++) begin
        if (mv[i] != 0 && mtag[i] == lt && e_hit == 0) begin
          e_hit = 1; e_hway = i; mv[i] = 0;
        end
      end
    end
    if (fv) begin
      free_w = -1;
      for (int i = NW-1; i >= 0; i--) if (mv[i] == 0) free_w = i;
      e_fage = ftc ? 3 : (duel ? 1 : 0);
      if (free_w >= 0) e_fway = free_w;
      else begin
        min_w = 0; min_a = mage[0];
        for (int i = 1; i < NW; i++) if (mage[i] < min_a) begin min_a = mage[i]; min_w = i; end
        e_ev = 1; e_evtag = mtag[min_w]; e_evtc = mtc[min_w];
        for (int i = 0; i < NW; i++) mage[i] = mage[i] - min_a;
        e_fway = min_w;
      end
      mv[e_fway] = 1; mtag[e_fway] = ft; mtc[e_fway] = ftc; mage[e_fway] = e_fage;
    end
    @(negedge clk_i);
    lookup_valid_i = lv; lookup_tag_i = TW'(lt);
    fill_valid_i = fv; fill_tag_i = TW'(ft); fill_tc_i = ftc; duel_sel_i = duel;
    @(negedge clk_i);
    lookup_valid_i = 0; fill_valid_i = 0;
    if (lv) begin
      chk(e_hit ? "R2 hit_o" : "R3 hit_o", int'(hit_o), e_hit);
      if (e_hit) begin
        chk("R2 hit_way_o", int'(hit_way_o), e_hway);
        chk("R2 hit_tc_o", int'(hit_tc_o), 1);
      end
    end else chk("R3 hit_o idle", int'(hit_o), 0);
    chk("R7 R8 R9 evict_valid_o", int'(evict_valid_o), e_ev);
    if (e_ev) begin
      chk("R7 R8 evict_tag_o", int'(evict_tag_o), e_evtag);
      chk("R10 evict_tc_o", int'(evict_tc_o), e_evtc);
    end
    if (fv) begin
      chk("R6 R7 fill_way_o", int'(fill_way_o), e_fway);
      chk(ftc ? "R4 fill_age_o" : "R5 fill_age_o", int'(fill_age_o), e_fage);
    end
  endtask

  task automatic do_fill(input bit tc, input bit duel);
    step(0, 0, 1, next_tag, tc, duel);
    next_tag++;
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin mv[i] = 0; mtag[i] = 0; mtc[i] = 0; mage[i] = 0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 hit_o", int'(hit_o), 0);
    chk("R1 hit_tc_o", int'(hit_tc_o), 0);
    chk("R1 evict_valid_o", int'(evict_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 evict_valid_o after release", int'(evict_valid_o), 0);
    step(1, 77, 0, 0, 0, 0);            // R3 miss on empty set
    do_fill(1, 0);                      // R4 R6 way0 age3
    do_fill(0, 0);                      // R5 way1 age0
    do_fill(0, 1);                      // R5 way2 age1
    do_fill(1, 1);                      // R4 way3 age3
    do_fill(0, 1);                      // R7 victim way1
    do_fill(0, 0);                      // R7 tie at age1, lowest way
    do_fill(1, 0);                      // R8 shifted ages decide
    step(1, 3, 0, 0, 0, 0);             // R2 hit
    step(1, 3, 0, 0, 0, 0);             // R2 line was freed: miss
    step(1, 999, 0, 0, 0, 0);           // R3 miss
    do_fill(0, 0);                      // R6 refill freed way
    // R9 full set, hit and fill together
    step(1, mtag[2], 1, next_tag, 0, 1); next_tag++;
    step(1, mtag[0], 1, next_tag, 1, 0); next_tag++;
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit lv, fv;
      int lt;
      lv = ($urandom_range(0, 2) == 0);
      fv = ($urandom_range(0, 3) != 0);
      lt = ($urandom_range(0, 3) == 0) ? 4000 : mtag[$urandom_range(0, NW-1)];
      step(lv, lt, fv, next_tag, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if (fv) next_tag = (next_tag % 3900) + 1;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule